// File: doc/BRIEF.md
# Address translation mode front end

This block sits ahead of the TLB and decides, for each virtual address, which translation path applies. With direct addressing enabled and paging disabled the address passes straight through, cut down to the physical width. Otherwise four mapping windows are checked, each qualified by the current privilege level. If no window claims the address, its upper bits must form a canonical sign extension. A canonical address becomes a TLB lookup request; any other address raises an address-error fault.

When the TLB returns a result code for the most recent lookup, the block turns it into a 6-bit exception code with a one-cycle valid pulse. The address and access type used for this come from the last lookup the block issued. The block also issues write strobes with data for the fault-address registers. A lookup miss drives the refill-side registers and raises a refill flag. Every other fault drives the normal bad-address register, unless a debug flag suppresses that write.

Top module: `xlat_front`

## Requirements
- R1: When a request is presented with `da_i`=1 and `pg_i`=0, one cycle later `res_valid_o` pulses with `mode_o`=0 (direct), `pa_o`=`va_i[47:0]` and `perm_o`=3'b111 ({read,write,exec}). This holds even if a window would match or the address is non-canonical.
- R2: Otherwise a window i (bits [64*i+63:64*i] of `win_cfg_i`) matches when its level enable is set and its bits [63:48] equal `va_i[63:48]`. Level 0 uses enable bit 0, level 3 uses enable bit 3, and levels 1 and 2 match no window. A match gives `mode_o`=1, `pa_o`=`va_i[47:0]`, `perm_o`=3'b111 and `win_idx_o`=i, even for a non-canonical address.
- R3: When several windows match, `win_idx_o` is the lowest matching index.
- R4: With no window match and `va_i[63:48]` all zeros or all ones, `mode_o`=2 and `lookup_o` pulses with `lookup_va_o`=`va_i`. The block keeps that address and `acc_i` for the next response.
- R5: With no window match and a non-canonical address, `mode_o`=3 and, in the same cycle, `exc_valid_o` pulses. `exc_code_o` is 8 for a fetch (`acc_i`=2) and 9 for any other access (`acc_i` 0 load, 1 store, 3 treated as load).
- R6: One cycle after `rsp_valid_i`, a result code of 2 (miss) or 3 (invalid) gives `exc_code_o` 1 for load, 2 for store and 3 for fetch, using the access type of the last issued lookup. This stays true when a new lookup is issued in the same cycle as the response.
- R7: Result code 4 (not dirty) gives 4, code 5 (read inhibited) gives 5, code 6 (execute inhibited) gives 6 and code 7 (privilege) gives 7. Code 1 gives 8 for fetch and 9 otherwise. Code 0 gives no exception pulse.
- R8: A miss exception sets `refill_o`, `rbadv_we_o` and `rehi_we_o`, with `rbadv_o` equal to the lookup address and `rehi_vppn_o` equal to its bits [47:13]. `badv_we_o` stays low.
- R9: Every other exception leaves `refill_o`, `rbadv_we_o` and `rehi_we_o` low. It drives `badv_we_o`=!`dbg_i`, with `dbg_i` sampled in the stimulus cycle, and `badv_o` equal to the faulting address.
- R10: If a non-canonical request and a lookup response arrive in the same cycle, only the request's address error is reported and the response is dropped.
- R11: During and right after reset all pulse outputs (`res_valid_o`, `lookup_o`, `exc_valid_o`, `refill_o`, the three write strobes) are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| va_i | input | 64 | Virtual address |
| acc_i | input | 2 | Access type: 0 load, 1 store, 2 fetch, 3 load |
| plv_i | input | 2 | Current privilege level |
| da_i | input | 1 | Direct-address mode bit |
| pg_i | input | 1 | Paging mode bit |
| win_cfg_i | input | 256 | Four mapping window registers, window i at bits [64*i+63:64*i] |
| dbg_i | input | 1 | Debug flag that suppresses the bad-address write |
| rsp_valid_i | input | 1 | TLB lookup result valid |
| rsp_code_i | input | 3 | TLB result code |
| res_valid_o | output | 1 | Translation decision pulse |
| mode_o | output | 2 | 0 direct, 1 window, 2 lookup, 3 fault |
| pa_o | output | 48 | Physical address for direct or window mode |
| perm_o | output | 3 | {read,write,exec} permission |
| win_idx_o | output | 2 | Matching window index |
| lookup_o | output | 1 | TLB lookup request pulse |
| lookup_va_o | output | 64 | Address of the lookup |
| exc_valid_o | output | 1 | Exception pulse |
| exc_code_o | output | 6 | Exception code |
| refill_o | output | 1 | Refill-in-progress set |
| rbadv_we_o | output | 1 | Refill bad-address register write |
| rbadv_o | output | 64 | Refill bad-address data |
| rehi_we_o | output | 1 | Refill entry-high page-pair write |
| rehi_vppn_o | output | 35 | Page-pair field data, address bits [47:13] |
| badv_we_o | output | 1 | Normal bad-address register write |
| badv_o | output | 64 | Normal bad-address data |

## Verification
Every output is registered, so a decision appears exactly one clock after its request, and an exception appears one clock after the request or response that caused it. The bench predicts the outputs from the inputs it drives on a falling edge and compares them on the next falling edge, one rising edge later. The prediction includes the pending lookup address and access type that a later response relies on. Data fields are compared only in cycles where their valid or strobe is expected high.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {ACC_LOAD = 2'd0, ACC_STORE = 2'd1, ACC_FETCH = 2'd2, ACC_RSVD = 2'd3} acc_e;
  typedef enum logic [1:0] {MODE_DIRECT = 2'd0, MODE_WINDOW = 2'd1, MODE_LOOKUP = 2'd2, MODE_FAULT = 2'd3} mode_e;
  typedef enum logic [2:0] {
    RC_OK = 3'd0, RC_BADADDR = 3'd1, RC_MISS = 3'd2, RC_INVALID = 3'd3,
    RC_NODIRTY = 3'd4, RC_NOREAD = 3'd5, RC_NOEXEC = 3'd6, RC_PRIV = 3'd7
  } rc_e;

  localparam logic [5:0] EC_NONE     = 6'd0;
  localparam logic [5:0] EC_INV_LD   = 6'd1;
  localparam logic [5:0] EC_INV_ST   = 6'd2;
  localparam logic [5:0] EC_INV_IF   = 6'd3;
  localparam logic [5:0] EC_MODIFY   = 6'd4;
  localparam logic [5:0] EC_NOREAD   = 6'd5;
  localparam logic [5:0] EC_NOEXEC   = 6'd6;
  localparam logic [5:0] EC_PRIV     = 6'd7;
  localparam logic [5:0] EC_ADDR_IF  = 6'd8;
  localparam logic [5:0] EC_ADDR_MEM = 6'd9;

  localparam int EN_BIT_KERN = 0;
  localparam int EN_BIT_USER = 3;
endpackage

// File: rtl/xlat_win_match.sv
module xlat_win_match
  import xlat_pkg::*;
#(
  parameter int AW    = 64,
  parameter int VA_W  = 48,
  parameter int NWIN  = 4,
  localparam int TW    = AW - VA_W,
  localparam int IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic [TW-1:0]      va_top_i,
  input  logic [1:0]         plv_i,
  input  logic [NWIN*AW-1:0] win_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [NWIN-1:0] cand;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    logic [AW-1:0] w;
    logic          en;
    logic          unused_fields;
    assign w  = win_i[g*AW +: AW];
    assign en = ((plv_i == 2'd0) && w[EN_BIT_KERN]) || ((plv_i == 2'd3) && w[EN_BIT_USER]);
    assign cand[g] = en && (w[AW-1:VA_W] == va_top_i);
    assign unused_fields = ^w[VA_W-1:0];
  end

  always_comb begin
    hit_o = |cand;
    idx_o = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (cand[i]) idx_o = i[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/xlat_canon.sv
module xlat_canon #(
  parameter int XW = 16
) (
  input  logic [XW-1:0] ext_i,
  output logic          ok_o
);
  assign ok_o = (&ext_i) || (~|ext_i);
endmodule

// File: rtl/xlat_exc_map.sv
module xlat_exc_map
  import xlat_pkg::*;
(
  input  rc_e        rc_i,
  input  acc_e       acc_i,
  output logic       fault_o,
  output logic       refill_o,
  output logic [5:0] code_o
);
  always_comb begin
    fault_o  = (rc_i != RC_OK);
    refill_o = (rc_i == RC_MISS);
    code_o   = EC_NONE;
    case (rc_i)
      RC_MISS, RC_INVALID: begin
        case (acc_i)
          ACC_STORE: code_o = EC_INV_ST;
          ACC_FETCH: code_o = EC_INV_IF;
          default:   code_o = EC_INV_LD;
        endcase
      end
      RC_NODIRTY: code_o = EC_MODIFY;
      RC_NOREAD:  code_o = EC_NOREAD;
      RC_NOEXEC:  code_o = EC_NOEXEC;
      RC_PRIV:    code_o = EC_PRIV;
      RC_BADADDR: code_o = (acc_i == ACC_FETCH) ? EC_ADDR_IF : EC_ADDR_MEM;
      default:    code_o = EC_NONE;
    endcase
  end
endmodule

// File: rtl/xlat_front.sv
module xlat_front
  import xlat_pkg::*;
#(
  parameter int AW      = 64,
  parameter int VA_W    = 48,
  parameter int PA_W    = 48,
  parameter int NWIN    = 4,
  parameter int VPPN_LO = 13,
  localparam int IDX_W  = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int VPPN_W = VA_W - VPPN_LO,
  localparam int XW     = AW - VA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [AW-1:0]      va_i,
  input  logic [1:0]         acc_i,
  input  logic [1:0]         plv_i,
  input  logic               da_i,
  input  logic               pg_i,
  input  logic [NWIN*AW-1:0] win_cfg_i,
  input  logic               dbg_i,
  input  logic               rsp_valid_i,
  input  logic [2:0]         rsp_code_i,
  output logic               res_valid_o,
  output logic [1:0]         mode_o,
  output logic [PA_W-1:0]    pa_o,
  output logic [2:0]         perm_o,
  output logic [IDX_W-1:0]   win_idx_o,
  output logic               lookup_o,
  output logic [AW-1:0]      lookup_va_o,
  output logic               exc_valid_o,
  output logic [5:0]         exc_code_o,
  output logic               refill_o,
  output logic               rbadv_we_o,
  output logic [AW-1:0]      rbadv_o,
  output logic               rehi_we_o,
  output logic [VPPN_W-1:0]  rehi_vppn_o,
  output logic               badv_we_o,
  output logic [AW-1:0]      badv_o
);
  logic             win_hit, canon_ok, direct;
  logic [IDX_W-1:0] win_idx;
  mode_e            mode_n;
  logic             req_fault, take, map_fault, map_refill, exc_n;
  rc_e              map_rc;
  acc_e             map_acc;
  logic [AW-1:0]    map_va;
  logic [5:0]       map_code;
  logic [1:0]       pend_acc;

  xlat_win_match #(.AW(AW), .VA_W(VA_W), .NWIN(NWIN)) u_win (
    .va_top_i (va_i[AW-1:VA_W]),
    .plv_i    (plv_i),
    .win_i    (win_cfg_i),
    .hit_o    (win_hit),
    .idx_o    (win_idx)
  );

  xlat_canon #(.XW(XW)) u_canon (
    .ext_i (va_i[AW-1:VA_W]),
    .ok_o  (canon_ok)
  );

  assign direct = da_i && !pg_i;

  always_comb begin
    if (direct)        mode_n = MODE_DIRECT;
    else if (win_hit)  mode_n = MODE_WINDOW;
    else if (canon_ok) mode_n = MODE_LOOKUP;
    else               mode_n = MODE_FAULT;
  end

  // a request's address error takes the single mapper ahead of a response
  assign req_fault = req_valid_i && (mode_n == MODE_FAULT);
  assign map_rc    = req_fault ? RC_BADADDR : rc_e'(rsp_code_i);
  assign map_acc   = req_fault ? acc_e'(acc_i) : acc_e'(pend_acc);
  assign map_va    = req_fault ? va_i : lookup_va_o;
  assign take      = req_fault || rsp_valid_i;

  xlat_exc_map u_map (
    .rc_i     (map_rc),
    .acc_i    (map_acc),
    .fault_o  (map_fault),
    .refill_o (map_refill),
    .code_o   (map_code)
  );

  assign exc_n = take && map_fault;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      mode_o      <= MODE_DIRECT;
      pa_o        <= '0;
      perm_o      <= '0;
      win_idx_o   <= '0;
      lookup_o    <= 1'b0;
      lookup_va_o <= '0;
      pend_acc    <= '0;
      exc_valid_o <= 1'b0;
      exc_code_o  <= EC_NONE;
      refill_o    <= 1'b0;
      rbadv_we_o  <= 1'b0;
      rbadv_o     <= '0;
      rehi_we_o   <= 1'b0;
      rehi_vppn_o <= '0;
      badv_we_o   <= 1'b0;
      badv_o      <= '0;
    end else begin
      res_valid_o <= req_valid_i;
      lookup_o    <= req_valid_i && (mode_n == MODE_LOOKUP);
      if (req_valid_i) begin
        mode_o    <= mode_n;
        pa_o      <= va_i[PA_W-1:0];
        perm_o    <= (mode_n == MODE_DIRECT || mode_n == MODE_WINDOW) ? 3'b111 : 3'b000;
        win_idx_o <= win_idx;
        if (mode_n == MODE_LOOKUP) begin
          lookup_va_o <= va_i;
          pend_acc    <= acc_i;
        end
      end
      exc_valid_o <= exc_n;
      refill_o    <= exc_n && map_refill;
      rbadv_we_o  <= exc_n && map_refill;
      rehi_we_o   <= exc_n && map_refill;
      badv_we_o   <= exc_n && !map_refill && !dbg_i;
      if (exc_n) begin
        exc_code_o  <= map_code;
        rbadv_o     <= map_va;
        rehi_vppn_o <= map_va[VA_W-1:VPPN_LO];
        badv_o      <= map_va;
      end
    end
  end

  AST_DIRECT_PA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && mode_o == MODE_DIRECT) |-> (pa_o == $past(va_i[PA_W-1:0]) && perm_o == 3'b111)); // R1
  AST_LOOKUP_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_o |-> (res_valid_o && mode_o == MODE_LOOKUP && lookup_va_o == $past(va_i))); // R4
  AST_FAULT_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && mode_o == MODE_FAULT) |-> (exc_valid_o && (exc_code_o == EC_ADDR_IF || exc_code_o == EC_ADDR_MEM))); // R5
  AST_EXC_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_o |-> ($past(req_valid_i) || $past(rsp_valid_i))); // R6
  AST_REFILL_REGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refill_o |-> (rbadv_we_o && rehi_we_o && !badv_we_o &&
                  (exc_code_o == EC_INV_LD || exc_code_o == EC_INV_ST || exc_code_o == EC_INV_IF))); // R8
  AST_BADV_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    badv_we_o |-> (exc_valid_o && !refill_o && !$past(dbg_i))); // R9
  AST_STROBES_NEED_EXC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rbadv_we_o || badv_we_o) |-> exc_valid_o); // R11
endmodule

// File: tb/tb_xlat_front.sv
module tb_xlat_front;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_v = 0, da = 0, pg = 1, dbg = 0, rsp_v = 0;
  logic [63:0] va = '0;
  logic [1:0]  acc = '0, plv = '0;
  logic [2:0]  rc = '0;
  logic [63:0] win [4];
  logic [255:0] win_flat;
  assign win_flat = {win[3], win[2], win[1], win[0]};

  logic        res_valid_o, lookup_o, exc_valid_o, refill_o, rbadv_we_o, rehi_we_o, badv_we_o;
  logic [1:0]  mode_o, win_idx_o;
  logic [47:0] pa_o;
  logic [2:0]  perm_o;
  logic [63:0] lookup_va_o, rbadv_o, badv_o;
  logic [5:0]  exc_code_o;
  logic [34:0] rehi_vppn_o;

  xlat_front dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_v), .va_i(va), .acc_i(acc), .plv_i(plv),
    .da_i(da), .pg_i(pg), .win_cfg_i(win_flat), .dbg_i(dbg), .rsp_valid_i(rsp_v), .rsp_code_i(rc),
    .res_valid_o(res_valid_o), .mode_o(mode_o), .pa_o(pa_o), .perm_o(perm_o), .win_idx_o(win_idx_o),
    .lookup_o(lookup_o), .lookup_va_o(lookup_va_o), .exc_valid_o(exc_valid_o), .exc_code_o(exc_code_o),
    .refill_o(refill_o), .rbadv_we_o(rbadv_we_o), .rbadv_o(rbadv_o), .rehi_we_o(rehi_we_o),
    .rehi_vppn_o(rehi_vppn_o), .badv_we_o(badv_we_o), .badv_o(badv_o)
  );

  int n_cmp = 0, n_bad = 0;
  logic [63:0] m_pva = '0;
  logic [1:0]  m_pacc = '0;

  logic e_rv, e_lk, e_exc, e_ref, e_rwe, e_bwe;
  int   e_mode, e_idx, e_code;
  logic [63:0] e_pa, e_lva, e_fva;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h exp %h", tag, what, act, exp);
    end
  endtask

  function automatic int map_code(int code, logic [1:0] a);
    if (code == 2 || code == 3) return (a == 2'd1) ? 2 : (a == 2'd2) ? 3 : 1;
    if (code == 1) return (a == 2'd2) ? 8 : 9;
    return code;
  endfunction

  task automatic predict();
    logic req_err;
    int hit;
    logic en;
    e_rv = 0; e_lk = 0; e_exc = 0; e_ref = 0; e_rwe = 0; e_bwe = 0;
    e_mode = 0; e_idx = 0; e_code = 0; e_pa = '0; e_lva = '0; e_fva = '0;
    req_err = 0;
    if (req_v) begin
      e_rv = 1;
      e_pa = {16'h0, va[47:0]};
      hit = -1;
      for (int i = 0; i < 4; i++) begin
        en = (plv == 2'd0) ? win[i][0] : (plv == 2'd3) ? win[i][3] : 1'b0;
        if (hit < 0 && en && win[i][63:48] == va[63:48]) hit = i;
      end
      if (da && !pg) e_mode = 0;
      else if (hit >= 0) begin e_mode = 1; e_idx = hit; end
      else if (va[63:48] == 16'h0 || va[63:48] == 16'hffff) begin
        e_mode = 2; e_lk = 1; e_lva = va;
      end else begin
        e_mode = 3; req_err = 1;
        e_exc = 1; e_code = map_code(1, acc); e_bwe = !dbg; e_fva = va;
      end
    end
    if (rsp_v && !req_err && rc != 3'd0) begin
      e_exc = 1; e_code = map_code(int'(rc), m_pacc); e_fva = m_pva;
      if (rc == 3'd2) begin e_ref = 1; e_rwe = 1; end
      else e_bwe = !dbg;
    end
    if (e_lk) begin m_pva = va; m_pacc = acc; end
  endtask

  task automatic compare(string tag);
    chk(tag, "res_valid", 64'(res_valid_o), 64'(e_rv));
    if (e_rv) chk(tag, "mode", 64'(mode_o), 64'(e_mode));
    if (e_rv && e_mode <= 1) begin
      chk(tag, "pa", 64'(pa_o), e_pa);
      chk(tag, "perm", 64'(perm_o), 64'h7);
    end
    if (e_rv && e_mode == 1) chk(tag, "win_idx", 64'(win_idx_o), 64'(e_idx));
    chk(tag, "lookup", 64'(lookup_o), 64'(e_lk));
    if (e_lk) chk(tag, "lookup_va", lookup_va_o, e_lva);
    chk(tag, "exc_valid", 64'(exc_valid_o), 64'(e_exc));
    if (e_exc) chk(tag, "exc_code", 64'(exc_code_o), 64'(e_code));
    chk(tag, "refill", 64'(refill_o), 64'(e_ref));
    chk(tag, "rbadv_we", 64'(rbadv_we_o), 64'(e_rwe));
    chk(tag, "rehi_we", 64'(rehi_we_o), 64'(e_rwe));
    chk(tag, "badv_we", 64'(badv_we_o), 64'(e_bwe));
    if (e_rwe) begin
      chk(tag, "rbadv", rbadv_o, e_fva);
      chk(tag, "rehi_vppn", 64'(rehi_vppn_o), 64'(e_fva[47:13]));
    end
    if (e_bwe) chk(tag, "badv", badv_o, e_fva);
  endtask

  task automatic cyc(string tag);
    predict();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    req_v = 0; rsp_v = 0; dbg = 0;
  endtask

  task automatic req(logic [63:0] a, logic [1:0] t, logic [1:0] l);
    req_v = 1; va = a; acc = t; plv = l;
  endtask

  task automatic rsp(logic [2:0] c);
    rsp_v = 1; rc = c;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R11 watchdog: got timeout exp finish");
    summary();
  end

  initial begin
    for (int i = 0; i < 4; i++) win[i] = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    predict();
    compare("R11");
    rst_n = 1;
    cyc("R11");

    // R1: direct mode beats windows and the canonical check
    win[1] = {16'h9000, 44'h0, 4'b0001};
    da = 1; pg = 0;
    req(64'hFFFF_1234_5678_9ABC, 2'd2, 2'd0); cyc("R1");
    req(64'h9000_0000_0040_1000, 2'd0, 2'd0); cyc("R1");
    da = 0; pg = 0;
    req(64'h0001_0000_0000_0000, 2'd0, 2'd0); cyc("R5");
    pg = 1;

    // R2: kernel window, user window, levels 1 and 2
    req(64'h9000_0000_0040_1000, 2'd0, 2'd0); cyc("R2");
    req(64'h9000_0000_0040_1000, 2'd1, 2'd3); cyc("R2");
    win[2] = {16'h9000, 44'h0, 4'b1000};
    req(64'h9000_0000_0040_1008, 2'd2, 2'd3); cyc("R2");
    req(64'h9000_0000_0040_1008, 2'd0, 2'd1); cyc("R2");
    req(64'h9000_0000_0040_1008, 2'd0, 2'd2); cyc("R2");
    req(64'h8000_0000_0040_1008, 2'd0, 2'd0); cyc("R2");

    // R3: lowest matching window wins
    win[3] = {16'h9000, 44'h0, 4'b1001};
    req(64'h9000_0000_0000_0010, 2'd0, 2'd3); cyc("R3");
    win[0] = {16'h9000, 44'h0, 4'b1001};
    req(64'h9000_0000_0000_0020, 2'd0, 2'd0); cyc("R3");
    req(64'h9000_0000_0000_0030, 2'd0, 2'd3); cyc("R3");

    // R4: canonical lookups
    req(64'h0000_0012_3456_7000, 2'd0, 2'd0); cyc("R4");
    req(64'hFFFF_8000_0000_2000, 2'd2, 2'd3); cyc("R4");

    // R5 / R9: address errors, debug suppression
    req(64'h0001_0000_0000_0000, 2'd2, 2'd0); cyc("R5");
    req(64'h7FFF_0000_0000_0040, 2'd0, 2'd0); cyc("R5");
    req(64'h0100_0000_0000_0040, 2'd3, 2'd3); cyc("R5");
    dbg = 1; req(64'h0001_0000_0000_0080, 2'd1, 2'd0); cyc("R9");

    // R6 / R8: miss and invalid by access type
    req(64'h0000_7654_3210_E000, 2'd1, 2'd0); cyc("R4");
    rsp(3'd2); cyc("R8");
    req(64'h0000_0000_1000_0000, 2'd0, 2'd3); cyc("R4");
    rsp(3'd3); cyc("R6");
    req(64'hFFFF_FFFF_FFFF_F000, 2'd2, 2'd0); cyc("R4");
    rsp(3'd3); cyc("R6");
    rsp(3'd2); cyc("R8");
    req(64'h0000_0000_2000_0000, 2'd3, 2'd0); cyc("R4");
    rsp(3'd2); cyc("R6");
    // response uses the old lookup while a new one issues
    req(64'h0000_0000_3000_0000, 2'd1, 2'd0); cyc("R4");
    req(64'h0000_0000_4000_0000, 2'd2, 2'd0); rsp(3'd3); cyc("R6");
    rsp(3'd3); cyc("R6");

    // R7: remaining result codes, with and without debug
    rsp(3'd4); cyc("R7");
    rsp(3'd5); cyc("R7");
    rsp(3'd6); cyc("R7");
    rsp(3'd7); cyc("R7");
    rsp(3'd1); cyc("R7");
    rsp(3'd0); cyc("R7");
    req(64'h0000_0000_5000_0000, 2'd0, 2'd0); cyc("R4");
    rsp(3'd1); cyc("R7");
    dbg = 1; rsp(3'd7); cyc("R9");
    dbg = 1; rsp(3'd2); cyc("R8");

    // R10: request fault beats a coincident response
    req(64'h0000_0000_6000_0000, 2'd1, 2'd0); cyc("R4");
    req(64'h1234_0000_0000_0000, 2'd2, 2'd0); rsp(3'd2); cyc("R10");
    cyc("R10");
    rsp(3'd2); cyc("R10");

    cyc("R11");
    summary();
  end
endmodule